// File: doc/BRIEF.md
# Double-Buffered Serial Converter Input Logic

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A serial bit stream enters a shift register, most significant bit first. A separate strobe then transfers the assembled word into the converter latch, which drives the analog stage. Codes are straight binary. Because the two stages have separate enables, several devices can be loaded one after another and then updated together.

Each clock strobe is one rising edge of `clk`. Two active-low selects are sampled on that edge and choose what the edge does:

| `shift_en_n` | `xfer_en_n` | Action on the edge |
|---|---|---|
| 0 | 1 | shift one bit into the input register |
| 1 | 0 | copy the input register into the converter latch |
| 0 | 0 | both at once (two-wire mode) |
| 1 | 1 | nothing |

An active-low asynchronous clear empties both stages. The most significant bit of the input register is brought out on `ser_out`, so devices can be chained on one data line.

Top module: `sdac_front`

## Requirements
- R1: The input register is 16 bits wide and is loaded MSB first. After 16 shifts and one transfer, `conv_word` equals the straight-binary word whose first transmitted bit is bit 15.
- R2: An edge with `shift_en_n`=0 and `xfer_en_n`=1 moves the register one place toward the MSB and puts `ser_in` into bit 0. `conv_word` is left unchanged.
- R3: An edge with `shift_en_n`=1 and `xfer_en_n`=0 copies the input register into `conv_word`. The input register is left unchanged.
- R4: An edge with both selects high changes neither stage. This holds whatever `ser_in` does.
- R5: An edge with both selects low shifts `ser_in` in and, on the same edge, sets `conv_word` to the newly shifted register value.
- R6: While `clr_n` is low, both stages read 0x0000. Clearing takes effect without any clock edge.
- R7: `ser_out` always equals bit 15 of the input register. Shifting a new word in therefore presents the previous word on `ser_out`, MSB first, one bit per shift.
- R8: Clear wins over any shift, transfer or two-wire edge that occurs while `clr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial strobe; the rising edge acts |
| clr_n | input | 1 | Asynchronous clear of both stages, active low |
| shift_en_n | input | 1 | Input register select, active low |
| xfer_en_n | input | 1 | Converter latch select, active low |
| ser_in | input | 1 | Serial data in, MSB first |
| ser_out | output | 1 | MSB of the input register, for chaining |
| conv_word | output | 16 | Word held in the converter latch |

## Verification
The input register has no output of its own. A fault in it therefore shows up in only two places:
- on `ser_out`, right after the shift that should have set the faulty bit, but only for bit 15;
- for lower bits, up to 15 shifts later on `ser_out`, or on `conv_word` after the next transfer.

For this reason, the bench shifts each word fully out through `ser_out`, and it also transfers words into the latch. A faulty latch shows at `conv_word` on the edge after the strobe. A faulty clear shows on both outputs within the same time step as the falling edge of `clr_n`, with no clock involved.

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en_n,
  input  logic             xfer_en_n,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] conv_word
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] in_reg;
  logic [WIDTH-1:0] in_next;

  assign in_next = shift_en_n ? in_reg : {in_reg[MSB-1:0], ser_in};
  assign ser_out = in_reg[MSB];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      in_reg    <= '0;
      conv_word <= '0;
    end else begin
      in_reg <= in_next;
      if (!xfer_en_n) conv_word <= in_next;
    end
  end

  // R2
  shift_keeps_latch_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!shift_en_n && xfer_en_n) |=> $stable(conv_word));

  // R2
  shift_feeds_msb_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!shift_en_n) |=> (ser_out == $past(in_reg[MSB-1])));

  // R3
  transfer_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en_n && !xfer_en_n) |=> (conv_word == $past(in_reg)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en_n && xfer_en_n) |=> ($stable(conv_word) && $stable(ser_out)));

  // R5
  two_wire_track_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!shift_en_n && !xfer_en_n) |=> (conv_word == in_reg));

  // R6 R8
  clear_zero_chk: assert property (@(posedge clk)
    (!clr_n) |-> (conv_word == '0 && !ser_out));
endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb;
  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic shift_en_n = 1'b1;
  logic xfer_en_n = 1'b1;
  logic ser_in = 1'b0;
  logic ser_out;
  logic [15:0] conv_word;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdac_front u_dut (
    .clk(clk), .clr_n(clr_n), .shift_en_n(shift_en_n), .xfer_en_n(xfer_en_n),
    .ser_in(ser_in), .ser_out(ser_out), .conv_word(conv_word)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic sn, input logic ln, input logic d);
    @(negedge clk);
    shift_en_n = sn; xfer_en_n = ln; ser_in = d;
    @(posedge clk);
    #2;
  endtask

  task automatic shift_word(input logic [15:0] w, output logic [15:0] seen);
    for (int i = 15; i >= 0; i--) begin
      seen[i] = ser_out;
      strobe(1'b0, 1'b1, w[i]);
    end
  endtask

  task automatic t_reset;
    chk("R6 reset latch", conv_word, 16'h0000);
    chk("R6 reset ser_out", {15'd0, ser_out}, 16'h0000);
  endtask

  task automatic t_shift_load;
    logic [15:0] seen;
    shift_word(16'hA5C3, seen);
    chk("R2 latch unchanged by shifts", conv_word, 16'h0000);
    chk("R7 ser_out is MSB", {15'd0, ser_out}, 16'h0001);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R1 R3 transfer MSB first", conv_word, 16'hA5C3);
  endtask

  task automatic t_idle;
    logic [15:0] seen;
    for (int i = 0; i < 6; i++) strobe(1'b1, 1'b1, i[0]);
    chk("R4 latch held when idle", conv_word, 16'hA5C3);
    shift_word(16'h1234, seen);
    chk("R4 R7 register kept, shifted out", seen, 16'hA5C3);
    chk("R2 latch kept during shifts", conv_word, 16'hA5C3);
    strobe(1'b1, 1'b0, 1'b1);
    chk("R3 second transfer", conv_word, 16'h1234);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R3 transfer leaves register", conv_word, 16'h1234);
  endtask

  task automatic t_two_wire;
    logic [15:0] exp = 16'h1234;
    logic [15:0] w = 16'h00FF;
    for (int i = 15; i >= 0; i--) begin
      strobe(1'b0, 1'b0, w[i]);
      exp = {exp[14:0], w[i]};
      if (i == 12 || i == 4 || i == 0) chk("R5 two-wire tracks", conv_word, exp);
    end
    strobe(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_clear;
    logic [15:0] seen;
    shift_word(16'hFFFF, seen);
    strobe(1'b1, 1'b1, 1'b0);
    #3 clr_n = 1'b0;
    #1;
    chk("R6 async clear latch", conv_word, 16'h0000);
    chk("R6 async clear ser_out", {15'd0, ser_out}, 16'h0000);
    strobe(1'b0, 1'b0, 1'b1);
    chk("R8 clear beats two-wire", conv_word, 16'h0000);
    strobe(1'b1, 1'b0, 1'b1);
    chk("R8 clear beats transfer", conv_word, 16'h0000);
    @(negedge clk);
    shift_en_n = 1'b1; xfer_en_n = 1'b1;
    clr_n = 1'b1;
    strobe(1'b1, 1'b0, 1'b0);
    chk("R6 input register cleared", conv_word, 16'h0000);
  endtask

  initial begin
    #1 clr_n = 1'b0;
    #30 clr_n = 1'b1;
    t_reset();
    t_shift_load();
    t_idle();
    t_two_wire();
    t_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule